// File: doc/BRIEF.md
# Transmit Descriptor List Walker

This block is the transmit side of a network adapter's DMA engine. Software places a list of buffer descriptors in 16-bit word-addressed memory. Each descriptor is six words long. Software then writes the list's start address through two register strobes. From there the block works through the list with no further help. For each descriptor it reads the control, address and length words. It then stamps the flag word so that software can see the entry has been taken over. Next it decides from the control word what the entry means: the end of the list, a link to another descriptor, or a data buffer. A data buffer is read word by word onto a transmit stream, and a completion status is then written into the descriptor.

The descriptor in memory acts as the ownership semaphore between software and the engine. The stamped flag word shows that the engine has taken an entry, and the written status word shows that the entry is done. Buffer lengths are stored as negative word counts. When a buffer that closes a packet has finished, the block raises its transmit-done status, which can also drive an interrupt line. When it meets an entry whose valid bit is clear, it raises its list-invalid status and stops.

Top module: `txdesc_walker`

## Requirements
- R1: A write on `list_hi_we` starts a walk only when a `list_lo_we` write came before it, with no other high write in between. The first descriptor address is {`list_wdata[5:0]` of the high write, the 16-bit value of the low write}. A high write with no preceding low write starts nothing.
- R2: For a descriptor at word address P, the block reads P+1 (control), P+2 (address low) and P+3 (length) in that order. It then writes 0xC000 to P+0.
- R3: When control bit 15 (valid) is clear, the block makes no further memory access after the flag write. It sets `xl_invalid` (the CSR bit of weight 0x0010) and returns to idle.
- R4: When control bit 13 (chain) is set on a valid entry, the next descriptor is read at {control[5:0], address low}. No buffer is read and no status is written for that entry.
- R5: For a valid, unchained entry, N = the two's-complement negation of the length word. The block reads N words from consecutive addresses that start at {control[5:0], address low}. Each word appears on `tx_data` with `tx_valid`, one cycle after its read completes.
- R6: When control bit 12 (end of message) is set, `tx_last` comes with the final word of that buffer. `xmit_int` (the CSR bit of weight 0x0080) is set once the entry's status write completes.
- R7: After a buffer entry, the block writes status word one (0x0000: collision count bits 7:4 and abort bit 9 both zero) to P+4. The next descriptor is at P+6.
- R8: A length word of zero reads no buffer words and produces no stream output. The status is still written.
- R9: `irq` is high exactly when `xmit_int` is set and `int_en` is high.
- R10: Starting a walk clears `xl_invalid` and `xmit_int`. A low/high write pair made while a walk is under way does not restart the walk and does not change it.
- R11: A memory request keeps its address, direction and write data unchanged until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| list_lo_we | input | 1 | Write strobe for the list address low part |
| list_hi_we | input | 1 | Write strobe for the list address high part (starts the walk) |
| list_wdata | input | 16 | Data for the list address writes |
| int_en | input | 1 | Interrupt enable |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 22 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, completes the request in this cycle |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| tx_valid | output | 1 | Transmit word valid |
| tx_data | output | 16 | Transmit word |
| tx_last | output | 1 | Final word of a packet |
| busy | output | 1 | A walk is in progress |
| xl_invalid | output | 1 | Transmit list invalid status |
| xmit_int | output | 1 | Transmit done status |
| irq | output | 1 | Interrupt request |

## Verification
The walker is tried with four list shapes. The first is a single end-of-message buffer followed by an invalid entry. This separates the stream order, the `tx_last` placement and the descriptor stepping of six words. The second is a chain link into a list at an address with high bits set, run while the memory stalls. This shows whether the link is followed without a buffer read or status write, and whether all 22 address bits are built correctly. The third is a zero-length entry, with a second start written mid-walk, which shows that status is still written and that the extra start is ignored. The last is a high-only write, which must produce no memory traffic at all.

// File: rtl/txw_pkg.sv
package txw_pkg;
  parameter int W_DATA = 16;
  parameter int W_ADDR = 22;

  localparam int BIT_VALID = 15;
  localparam int BIT_CHAIN = 13;
  localparam int BIT_EOM   = 12;

  localparam int OFS_FLAG   = 0;
  localparam int OFS_CTRL   = 1;
  localparam int OFS_ALO    = 2;
  localparam int OFS_LEN    = 3;
  localparam int OFS_STAT   = 4;
  localparam int DESC_WORDS = 6;

  localparam logic [15:0] FLAG_STAMP = 16'hC000;
  localparam logic [15:0] STAT_DONE  = 16'h0000;

  typedef enum logic [2:0] {
    WS_IDLE, WS_CTRL, WS_ALO, WS_LEN, WS_FLAG, WS_BUF, WS_STAT
  } walk_state_e;
endpackage

// File: rtl/txw_listbase.sv
module txw_listbase #(
  parameter int DW = txw_pkg::W_DATA,
  parameter int AW = txw_pkg::W_ADDR,
  localparam int HI_W = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output logic [AW-1:0] start_base,
  output logic          ev_start
);
  logic [DW-1:0] lo_q;
  logic          lo_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      lo_seen <= 1'b0;
    end else begin
      if (lo_we) begin
        lo_q    <= wdata;
        lo_seen <= 1'b1;
      end
      if (hi_we) lo_seen <= 1'b0;
    end
  end

  assign start_base = {wdata[HI_W-1:0], lo_q};
  assign ev_start   = hi_we && lo_seen && !busy;
endmodule

// File: rtl/txw_walker.sv
module txw_walker
  import txw_pkg::*;
#(
  parameter int DW = txw_pkg::W_DATA,
  parameter int AW = txw_pkg::W_ADDR,
  localparam int HI_W = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic          busy,
  output logic          ev_invalid,
  output logic          ev_eom_done
);
  function automatic logic [DW-1:0] word_count(input logic [DW-1:0] len);
    return DW'(0) - len;
  endfunction

  function automatic logic [AW-1:0] join_addr(input logic [HI_W-1:0] hi,
                                              input logic [DW-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [AW-1:0] desc_word(input logic [AW-1:0] p, input int ofs);
    return p + AW'(ofs);
  endfunction

  walk_state_e   state;
  logic [AW-1:0] ptr, buf_ptr;
  logic [DW-1:0] alo, cnt;
  logic [HI_W-1:0] c_hi;
  logic          c_valid, c_chain, c_eom;
  logic          done;

  assign done        = mem_req && mem_ack;
  assign busy        = (state != WS_IDLE);
  assign mem_req     = busy;
  assign ev_invalid  = (state == WS_FLAG) && done && !c_valid;
  assign ev_eom_done = (state == WS_STAT) && done && c_eom;

  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = STAT_DONE;
    mem_addr  = ptr;
    unique case (state)
      WS_CTRL: mem_addr = desc_word(ptr, OFS_CTRL);
      WS_ALO:  mem_addr = desc_word(ptr, OFS_ALO);
      WS_LEN:  mem_addr = desc_word(ptr, OFS_LEN);
      WS_FLAG: begin
        mem_addr  = desc_word(ptr, OFS_FLAG);
        mem_we    = 1'b1;
        mem_wdata = FLAG_STAMP;
      end
      WS_BUF:  mem_addr = buf_ptr;
      WS_STAT: begin
        mem_addr = desc_word(ptr, OFS_STAT);
        mem_we   = 1'b1;
      end
      default: mem_addr = ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= WS_IDLE;
      ptr      <= '0;
      buf_ptr  <= '0;
      alo      <= '0;
      cnt      <= '0;
      c_hi     <= '0;
      c_valid  <= 1'b0;
      c_chain  <= 1'b0;
      c_eom    <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_last  <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      unique case (state)
        WS_IDLE: if (start) begin
          ptr   <= base;
          state <= WS_CTRL;
        end
        WS_CTRL: if (done) begin
          c_valid <= mem_rdata[BIT_VALID];
          c_chain <= mem_rdata[BIT_CHAIN];
          c_eom   <= mem_rdata[BIT_EOM];
          c_hi    <= mem_rdata[HI_W-1:0];
          state   <= WS_ALO;
        end
        WS_ALO: if (done) begin
          alo   <= mem_rdata;
          state <= WS_LEN;
        end
        WS_LEN: if (done) begin
          cnt   <= word_count(mem_rdata);
          state <= WS_FLAG;
        end
        WS_FLAG: if (done) begin
          if (!c_valid) begin
            state <= WS_IDLE;
          end else if (c_chain) begin
            ptr   <= join_addr(c_hi, alo);
            state <= WS_CTRL;
          end else begin
            buf_ptr <= join_addr(c_hi, alo);
            state   <= (cnt == '0) ? WS_STAT : WS_BUF;
          end
        end
        WS_BUF: if (done) begin
          tx_valid <= 1'b1;
          tx_data  <= mem_rdata;
          tx_last  <= c_eom && (cnt == DW'(1));
          cnt      <= cnt - DW'(1);
          buf_ptr  <= buf_ptr + AW'(1);
          if (cnt == DW'(1)) state <= WS_STAT;
        end
        WS_STAT: if (done) begin
          ptr   <= desc_word(ptr, DESC_WORDS);
          state <= WS_CTRL;
        end
        default: state <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txw_status.sv
module txw_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_start,
  input  logic ev_invalid,
  input  logic ev_eom_done,
  input  logic int_en,
  output logic xl_invalid,
  output logic xmit_int,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xl_invalid <= 1'b0;
      xmit_int   <= 1'b0;
    end else begin
      if (ev_start) begin
        xl_invalid <= 1'b0;
        xmit_int   <= 1'b0;
      end
      if (ev_invalid)  xl_invalid <= 1'b1;
      if (ev_eom_done) xmit_int   <= 1'b1;
    end
  end

  assign irq = xmit_int && int_en;
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker #(
  parameter int DW = txw_pkg::W_DATA,
  parameter int AW = txw_pkg::W_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          list_lo_we,
  input  logic          list_hi_we,
  input  logic [DW-1:0] list_wdata,
  input  logic          int_en,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic          busy,
  output logic          xl_invalid,
  output logic          xmit_int,
  output logic          irq
);
  logic [AW-1:0] start_base;
  logic          ev_start, ev_invalid, ev_eom_done;

  txw_listbase #(.DW(DW), .AW(AW)) u_base (
    .clk(clk), .rst_n(rst_n), .lo_we(list_lo_we), .hi_we(list_hi_we),
    .wdata(list_wdata), .busy(busy), .start_base(start_base), .ev_start(ev_start)
  );

  txw_walker #(.DW(DW), .AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(ev_start), .base(start_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .busy(busy), .ev_invalid(ev_invalid), .ev_eom_done(ev_eom_done)
  );

  txw_status u_stat (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_invalid(ev_invalid),
    .ev_eom_done(ev_eom_done), .int_en(int_en),
    .xl_invalid(xl_invalid), .xmit_int(xmit_int), .irq(irq)
  );
endmodule

// File: rtl/txdesc_walker_chk.sv
module txdesc_walker_chk #(
  parameter int DW = 16,
  parameter int AW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_start,
  input logic          ev_eom_done,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          tx_valid,
  input logic          tx_last,
  input logic          xl_invalid,
  input logic          xmit_int
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_start_runs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> busy);

  assert_invalid_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xl_invalid) |-> !busy);

  assert_last_with_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_done_from_eom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xmit_int) |-> $past(ev_eom_done));

  assert_word_in_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(busy));
endmodule

bind txdesc_walker txdesc_walker_chk #(.DW(DW), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_eom_done(ev_eom_done),
  .busy(busy), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tx_valid(tx_valid),
  .tx_last(tx_last), .xl_invalid(xl_invalid), .xmit_int(xmit_int)
);

// File: tb/txdesc_walker_test.sv
`timescale 1ns/1ps
module txdesc_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        list_lo_we = 1'b0, list_hi_we = 1'b0, int_en = 1'b0;
  logic [15:0] list_wdata = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [21:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0, tx_data;
  logic        tx_valid, tx_last, busy, xl_invalid, xmit_int, irq;

  int checks = 0, fails = 0, cyc = 0, stall_cnt = 0;
  bit stall = 0, finished = 0;
  logic [15:0] mem [0:1023];
  logic [38:0] exp_mem [$];
  logic [16:0] exp_tx [$];
  bit exp_inv, exp_int;

  always #2 clk = ~clk;

  txdesc_walker uut (
    .clk(clk), .rst_n(rst_n), .list_lo_we(list_lo_we), .list_hi_we(list_hi_we),
    .list_wdata(list_wdata), .int_en(int_en), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .busy(busy),
    .xl_invalid(xl_invalid), .xmit_int(xmit_int), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: one-cycle acknowledge, optional stalls
  always @(posedge clk) begin
    cyc++;
    stall_cnt = (stall_cnt == 2) ? 0 : stall_cnt + 1;
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack && (!stall || stall_cnt == 0)) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
      else mem_rdata <= mem[mem_addr[9:0]];
    end else mem_ack <= 1'b0;
  end

  // per-cycle comparison against the reference queues
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (exp_mem.size() == 0)
        chk(0, "R10 unexpected memory access", {mem_we, mem_addr, mem_wdata}, 0);
      else begin
        logic [38:0] e;
        e = exp_mem.pop_front();
        if (e[38])
          chk({mem_we, mem_addr, mem_wdata} == e, "R2/R7 memory write", {mem_we, mem_addr, mem_wdata}, e);
        else
          chk({mem_we, mem_addr} == e[38:16], "R2/R4/R5 memory read", {mem_we, mem_addr}, e[38:16]);
      end
    end
    if (rst_n && tx_valid) begin
      if (exp_tx.size() == 0) chk(0, "R5 unexpected tx word", {tx_last, tx_data}, 0);
      else begin
        logic [16:0] t;
        t = exp_tx.pop_front();
        chk({tx_last, tx_data} == t, "R5/R6 tx word", {tx_last, tx_data}, t);
      end
    end
    if (rst_n) chk(irq == (xmit_int && int_en), "R9 irq", irq, xmit_int && int_en);
  end

  // behavioural model of a walk
  task automatic model(input logic [21:0] base);
    logic [21:0] p, a;
    logic [15:0] c, n;
    p = base;
    exp_inv = 0; exp_int = 0;
    for (int k = 0; k < 40; k++) begin
      c = mem[10'(p + 1)];
      exp_mem.push_back({1'b0, 22'(p + 1), 16'h0});
      exp_mem.push_back({1'b0, 22'(p + 2), 16'h0});
      exp_mem.push_back({1'b0, 22'(p + 3), 16'h0});
      exp_mem.push_back({1'b1, p, 16'hC000});
      if (!c[15]) begin exp_inv = 1; break; end
      a = {c[5:0], mem[10'(p + 2)]};
      if (c[13]) begin p = a; continue; end
      n = 16'h0 - mem[10'(p + 3)];
      for (int i = 0; i < int'(n); i++) begin
        exp_mem.push_back({1'b0, 22'(a + 22'(i)), 16'h0});
        exp_tx.push_back({c[12] && (i == int'(n) - 1), mem[10'(a + 22'(i))]});
      end
      exp_mem.push_back({1'b1, 22'(p + 4), 16'h0000});
      if (c[12]) exp_int = 1;
      p = p + 22'd6;
    end
  endtask

  task automatic put_desc(input int p, input logic [15:0] c, input logic [15:0] lo, input logic [15:0] len);
    mem[p] = 16'h1111; mem[p+1] = c; mem[p+2] = lo; mem[p+3] = len; mem[p+4] = 16'hFFFF;
  endtask

  task automatic kick(input logic [21:0] base, input bit with_lo);
    if (with_lo) begin
      list_wdata = base[15:0]; list_lo_we = 1; @(negedge clk); list_lo_we = 0;
    end
    list_wdata = {10'h0, base[21:16]}; list_hi_we = 1; @(negedge clk); list_hi_we = 0;
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(!busy, {tag, " walk ends"}, busy, 0);
    chk(exp_mem.size() == 0, {tag, " all memory accesses seen"}, exp_mem.size(), 0);
    chk(exp_tx.size() == 0, {tag, " all tx words seen"}, exp_tx.size(), 0);
    chk(xl_invalid == exp_inv, {tag, " R3 xl_invalid"}, xl_invalid, exp_inv);
    chk(xmit_int == exp_int, {tag, " R6 xmit_int"}, xmit_int, exp_int);
  endtask

  always @(posedge clk) if (cyc > 100000 && !finished) begin
    finished = 1;
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 16'h0107 ^ 16'h5A5A);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({mem_req, tx_valid, busy, xl_invalid, xmit_int, irq} == 6'b0, "reset state",
        {mem_req, tx_valid, busy, xl_invalid, xmit_int, irq}, 0);

    // S1: one end-of-message buffer of 3 words, then an invalid entry (R2 R5 R6 R7 R9)
    int_en = 1;
    put_desc(16'h010, 16'h9000, 16'h0100, 16'hFFFD);
    put_desc(16'h016, 16'h0000, 16'h0000, 16'h0000);
    model(22'h000010);
    kick(22'h000010, 1);
    wait_idle("S1");
    chk(mem[16'h010] == 16'hC000, "R2 flag stamped", mem[16'h010], 16'hC000);
    chk(mem[16'h014] == 16'h0000, "R7 status written", mem[16'h014], 16'h0000);
    chk(irq == 1'b1, "R9 irq with enable", irq, 1);

    // S2: chain link from a high base, stalled memory, interrupt disabled (R1 R4 R11)
    int_en = 0; stall = 1;
    put_desc(16'h040, 16'hA000, 16'h0080, 16'h1234);
    put_desc(16'h080, 16'h8003, 16'h0200, 16'hFFFE);
    put_desc(16'h086, 16'h9000, 16'h0210, 16'hFFFF);
    put_desc(16'h08C, 16'h2000, 16'h0000, 16'h0000);
    model(22'h200040);
    kick(22'h200040, 1);
    wait_idle("S2");
    chk(mem[16'h044] == 16'hFFFF, "R4 no status on chain entry", mem[16'h044], 16'hFFFF);
    chk(irq == 1'b0, "R9 irq masked", irq, 0);
    stall = 0;

    // S3: zero-length entry, with a second start written mid-walk (R8 R10)
    put_desc(16'h0C0, 16'h8000, 16'h0300, 16'h0000);
    put_desc(16'h0C6, 16'h0000, 16'h0000, 16'h0000);
    model(22'h0000C0);
    kick(22'h0000C0, 1);
    chk(xmit_int == 1'b0, "R10 start clears xmit_int", xmit_int, 0);
    kick(22'h000010, 1);
    wait_idle("S3 R8");
    chk(mem[16'h0C4] == 16'h0000, "R8 status after empty buffer", mem[16'h0C4], 0);

    // S4: high write alone must not start (R1)
    kick(22'h000010, 0);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R1 high write without low", busy, 0);
    chk(xl_invalid == 1'b1, "R1 status kept without start", xl_invalid, 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule